// File: doc/BRIEF.md
# Sync-Triggered Channel Start Controller

This block decides when each of four sleeping processing channels wakes up. Each channel watches one of four external sync inputs (A, B, C, D). The channel must have its start function enabled, and the chosen input must be among the pins it is allowed to respond to.

A qualifying rising edge arms a per-channel 16-bit hold-off count. That count runs down on the system clock. When it expires, the channel's sleep flag drops and a one-cycle start pulse is issued. The whole path, from the first clock edge that samples the pin high to the edge that clears sleep, takes exactly the programmed hold-off plus three cycles.

Software programs every channel through a small write port. Each channel has two words: the hold-off count and a control word. A global synchronous reset sends every channel back to sleep. A channel may be told to honour only its first trigger. In that mode, later edges are ignored until the flag is written back to zero.

Top module: `chan_start_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, every bit of `ch_sleep` becomes 1, every bit of `ch_start` becomes 0, each hold-off word becomes 1 and each control word becomes 0.
- R2: A write with `wr_en`=1 goes to channel `wr_ch`. With `wr_addr`=0 it loads the 16-bit hold-off from `wr_data`. With `wr_addr`=1 it loads the control word: bit 0 is start enable, bits 4:1 are the pin enables for A..D (bit 1 = A), bits 6:5 are the pin select, and bit 7 is first-only.
- R3: Pin select code 00 picks A, 01 picks B, 10 picks C and 11 picks D. Edges on pins that are not selected never start the channel.
- R4: An edge on the selected pin is used only if that pin's enable bit is 1.
- R5: No pin edge starts a channel whose start enable bit is 0.
- R6: If the selected pin is first sampled high at clock edge k, the channel's sleep flag is 0 after edge k+H+3, and still 1 after edge k+H+2, where H is the hold-off.
- R7: A hold-off of 0 behaves as 1. Any hold-off from 1 to 65535 is honoured exactly.
- R8: A new rising edge restarts the count, so the latency is measured from the latest trigger. If a restart reaches the counter in the same cycle as an expiry, the expiry still completes and the new count also runs, giving a second start pulse H+3 cycles after the second edge.
- R9: With first-only set, only the first accepted trigger is used and later edges are ignored. Writing the control word with first-only at 0 re-arms the channel.
- R10: A pin held high for many cycles counts as a single trigger.
- R11: `ch_start[c]` is high for exactly one cycle, in the cycle in which the count for channel c expires. On the first wake this is the same cycle in which `ch_sleep[c]` falls.
- R12: Channels are independent. One pin may wake several channels, each after its own hold-off, and channels not started stay asleep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_pin | input | 4 | External sync inputs, bit 0 = A to bit 3 = D (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | 2 | Channel addressed by the write |
| wr_addr | input | 1 | 0 = hold-off word, 1 = control word |
| wr_data | input | 16 | Write data |
| ch_sleep | output | 4 | Per-channel sleep flag, 1 = asleep |
| ch_start | output | 4 | Per-channel one-cycle start pulse |

## Verification
Two events can land on the same clock edge: a count reaching its end, and a fresh trigger reloading that same counter. The bench provokes this with a hold-off of 5. The second rise on the pin is placed exactly five cycles after the first, so the reload arrives on the edge where the first count expires. The check expects two start pulses, eight and thirteen cycles after the first rise, and expects the sleep flag to fall on the first of them. If either pulse is missing, or appears in the wrong cycle, that is reported as a failure.

// File: rtl/chan_start_pkg.sv
// Shared constants and types for the sync-triggered start controller.
// Assumes exactly four sync inputs, so a 2-bit code addresses any of them.
package chan_start_pkg;

    localparam int PIN_N = 4;
    localparam int SEL_W = $clog2(PIN_N);

    // Per-channel control fields decoded from the control word.
    typedef struct packed {
        logic             first_only;
        logic [SEL_W-1:0] pin_sel;
        logic [PIN_N-1:0] pin_en;
        logic             start_en;
    } ch_ctrl_t;

    localparam int CTRL_W = $bits(ch_ctrl_t);

endpackage

// File: rtl/pin_sync_edge.sv
// Brings one asynchronous sync pin into the clock domain and flags its
// rising edge for one cycle. Assumes the pin stays high or low for at least
// one clock period. The chain depth sets part of the fixed start latency.
module pin_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Shift the pin through the synchronizer chain and keep the last value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    // A new high after a low is one trigger.
    always_comb rise = chain_q[STAGES-1] & ~prev_q;

    // R10: a held pin yields a single-cycle edge flag
    a_r10_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/chan_cfg_regs.sv
// Per-channel configuration: the hold-off word, the control word and the
// first-trigger latch. Assumes the write strobe is already decoded for
// this channel. The latch is cleared when first-only is written as zero.
module chan_cfg_regs
    import chan_start_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             accepted,
    output logic [CNT_W-1:0] holdoff,
    output ch_ctrl_t         ctrl,
    output logic             blocked
);

    localparam logic [CNT_W-1:0] HOLD_RST = CNT_W'(1);

    logic taken_q;

    // Capture register writes for this channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            holdoff <= HOLD_RST;
            ctrl    <= '0;
        end else if (wr_en) begin
            if (wr_addr) ctrl    <= ch_ctrl_t'(wr_data[CTRL_W-1:0]);
            else         holdoff <= wr_data;
        end
    end

    // Remember that a trigger was used; a control write with first-only low re-arms.
    always_ff @(posedge clk) begin
        if (!rst_n)
            taken_q <= 1'b0;
        else if (wr_en && wr_addr && !wr_data[CTRL_W-1])
            taken_q <= 1'b0;
        else if (accepted)
            taken_q <= 1'b1;
    end

    always_comb blocked = ctrl.first_only & taken_q;

    // R9: once blocked, only a control write can release the channel
    a_r9_block_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked && !(wr_en && wr_addr)) |=> blocked);

endmodule

// File: rtl/chan_holdoff_timer.sv
// Hold-off timer for one channel. A trigger is registered once, the
// hold-off is snapshotted with it, then the count is loaded and runs down.
// At a count of one the sleep flag clears and a start pulse is issued.
// Assumes the trigger is already qualified. The latency from trigger to
// expiry is H+1 edges.
module chan_holdoff_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic [CNT_W-1:0] holdoff,
    output logic             sleep,
    output logic             start_pulse
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic             trig_q;
    logic [CNT_W-1:0] val_q;
    logic [CNT_W-1:0] cnt_q;
    logic             active_q;
    logic             expire;

    always_comb expire = active_q && (cnt_q == ONE);

    // Register the trigger and snapshot the hold-off, treating zero as one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= 1'b0;
            val_q  <= ONE;
        end else begin
            trig_q <= trig;
            if (trig) val_q <= (holdoff == '0) ? ONE : holdoff;
        end
    end

    // Load on a registered trigger, otherwise count down while active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else if (trig_q) begin
            cnt_q    <= val_q;
            active_q <= 1'b1;
        end else if (active_q) begin
            if (expire) active_q <= 1'b0;
            else        cnt_q    <= cnt_q - ONE;
        end
    end

    // Clear sleep and pulse start when the count expires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sleep       <= 1'b1;
            start_pulse <= 1'b0;
        end else begin
            start_pulse <= expire;
            if (expire) sleep <= 1'b0;
        end
    end

    // R1: after reset only reset can put the channel back to sleep
    a_r1_sleep_only_by_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(sleep));

    // R11: the sleep flag never falls without a start pulse
    a_r11_pulse_on_wake: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep) |-> start_pulse);

    // R6: an unloaded running count drops by exactly one per cycle
    a_r6_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !trig_q && cnt_q > ONE) |=> (cnt_q == $past(cnt_q) - ONE));

    // R7: a running count is never zero
    a_r7_no_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> (cnt_q != '0));

endmodule

// File: rtl/chan_start_ctrl.sv
// Top of the sync-triggered start controller. Synchronizes all sync pins
// once, then per channel qualifies the selected pin's edge by the start
// enable, the pin enable and the first-only latch, and runs a hold-off
// timer. Total latency from first sampled high to sleep clear is H+3 edges
// with SYNC_STAGES = 2.
module chan_start_ctrl
    import chan_start_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIN_N-1:0]  sync_pin,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic              wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [NUM_CH-1:0] ch_sleep,
    output logic [NUM_CH-1:0] ch_start
);

    logic [PIN_N-1:0] pin_rise;

    // One synchronizer and edge detector per sync pin, shared by all channels.
    for (genvar p = 0; p < PIN_N; p++) begin : g_pin
        pin_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (sync_pin[p]),
            .rise  (pin_rise[p])
        );
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic             ch_wr;
        logic             trig;
        logic             blocked;
        logic [CNT_W-1:0] holdoff;
        ch_ctrl_t         ctrl;

        always_comb ch_wr = wr_en && (wr_ch == CH_W'(c));

        // Qualify the selected pin's edge.
        always_comb trig = ctrl.start_en && ctrl.pin_en[ctrl.pin_sel]
                           && pin_rise[ctrl.pin_sel] && !blocked;

        chan_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (ch_wr),
            .wr_addr  (wr_addr),
            .wr_data  (wr_data),
            .accepted (trig),
            .holdoff  (holdoff),
            .ctrl     (ctrl),
            .blocked  (blocked)
        );

        chan_holdoff_timer #(.CNT_W(CNT_W)) u_timer (
            .clk         (clk),
            .rst_n       (rst_n),
            .trig        (trig),
            .holdoff     (holdoff),
            .sleep       (ch_sleep[c]),
            .start_pulse (ch_start[c])
        );

        // R5: a disabled channel never accepts a trigger
        a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !ctrl.start_en |-> !trig);
    end

endmodule

// File: tb/sim_chan_start_ctrl.sv
// Bench for chan_start_ctrl: directed corner cases plus seeded random runs.
module sim_chan_start_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  sync_pin = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_ch = '0;
    logic        wr_addr = 1'b0;
    logic [15:0] wr_data = '0;
    logic [3:0]  ch_sleep;
    logic [3:0]  ch_start;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int wake_i [4];
    int firstp [4];
    int lastp  [4];
    int npul   [4];

    always #4 clk = ~clk;

    chan_start_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .sync_pin(sync_pin), .wr_en(wr_en),
        .wr_ch(wr_ch), .wr_addr(wr_addr), .wr_data(wr_data),
        .ch_sleep(ch_sleep), .ch_start(ch_start)
    );

    function automatic logic [15:0] ctrl_word(input bit en, input logic [3:0] pen,
                                              input logic [1:0] sel, input bit fo);
        return {8'h00, fo, sel, pen, en};
    endfunction

    function automatic int exp_wake(input int r, input int h);
        return r + ((h == 0) ? 1 : h) + 3;
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        sync_pin = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input int ch, input bit addr, input logic [15:0] data);
        wr_en = 1'b1; wr_ch = 2'(ch); wr_addr = addr; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Drive one pin with up to two pulses; observe every channel each cycle.
    task automatic run(input int pin, input int r1, input int r2,
                       input int hold, input int total);
        for (int c = 0; c < 4; c++) begin
            wake_i[c] = -1; firstp[c] = -1; lastp[c] = -1; npul[c] = 0;
        end
        for (int i = 0; i < total; i++) begin
            bit hi;
            hi = (i >= r1 && i < r1 + hold) || (r2 >= 0 && i >= r2 && i < r2 + hold);
            sync_pin = '0;
            sync_pin[pin] = hi;
            @(posedge clk);
            @(negedge clk);
            for (int c = 0; c < 4; c++) begin
                if (!ch_sleep[c] && wake_i[c] < 0) wake_i[c] = i;
                if (ch_start[c]) begin
                    npul[c]++;
                    if (firstp[c] < 0) firstp[c] = i;
                    lastp[c] = i;
                end
            end
        end
        sync_pin = '0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();
        chk("R1 sleep after reset", ch_sleep, 4'hF);
        chk("R1 start after reset", ch_start, 4'h0);

        // R3: channel 0 selects C; A, B and D must not start it
        wr(0, 1'b0, 16'd4);
        wr(0, 1'b1, ctrl_word(1'b1, 4'hF, 2'd2, 1'b0));
        run(0, 0, -1, 3, 20); chk("R3 pin A ignored", wake_i[0], -1);
        run(1, 0, -1, 3, 20); chk("R3 pin B ignored", wake_i[0], -1);
        run(3, 0, -1, 3, 20); chk("R3 pin D ignored", wake_i[0], -1);
        run(2, 0, -1, 3, 15);
        chk("R6 wake latency sel C", wake_i[0], exp_wake(0, 4));
        chk("R11 pulse in wake cycle", firstp[0], wake_i[0]);
        chk("R11 single pulse", npul[0], 1);

        // R4: selected pin disabled, then enabled
        do_reset();
        wr(1, 1'b0, 16'd2);
        wr(1, 1'b1, ctrl_word(1'b1, 4'b1101, 2'd1, 1'b0));
        run(1, 0, -1, 3, 20); chk("R4 disabled pin ignored", wake_i[1], -1);
        wr(1, 1'b1, ctrl_word(1'b1, 4'b0010, 2'd1, 1'b0));
        run(1, 0, -1, 3, 20); chk("R4 enabled pin wakes", wake_i[1], exp_wake(0, 2));

        // R5: start enable low
        do_reset();
        wr(2, 1'b1, ctrl_word(1'b0, 4'hF, 2'd3, 1'b0));
        run(3, 0, -1, 3, 30); chk("R5 start disabled", wake_i[2], -1);

        // R7: zero hold-off acts as one; a long hold-off is exact
        do_reset();
        wr(3, 1'b0, 16'd0);
        wr(3, 1'b1, ctrl_word(1'b1, 4'h1, 2'd0, 1'b0));
        run(0, 0, -1, 3, 12); chk("R7 zero hold-off", wake_i[3], exp_wake(0, 0));
        do_reset();
        wr(3, 1'b0, 16'd1000);
        wr(3, 1'b1, ctrl_word(1'b1, 4'h1, 2'd0, 1'b0));
        run(0, 2, -1, 3, 1010); chk("R7 hold-off 1000", wake_i[3], exp_wake(2, 1000));

        // R10: a pin held high is one trigger
        do_reset();
        wr(0, 1'b0, 16'd4);
        wr(0, 1'b1, ctrl_word(1'b1, 4'h8, 2'd3, 1'b0));
        run(3, 0, -1, 40, 60);
        chk("R10 held pin wake", wake_i[0], exp_wake(0, 4));
        chk("R10 held pin one pulse", npul[0], 1);

        // R8: retrigger restarts the count
        do_reset();
        wr(1, 1'b0, 16'd10);
        wr(1, 1'b1, ctrl_word(1'b1, 4'h4, 2'd2, 1'b0));
        run(2, 0, 4, 2, 40);
        chk("R8 retrigger latency", wake_i[1], exp_wake(4, 10));
        chk("R8 retrigger one pulse", npul[1], 1);

        // R8: reload lands on the expiry edge
        do_reset();
        wr(2, 1'b0, 16'd5);
        wr(2, 1'b1, ctrl_word(1'b1, 4'h2, 2'd1, 1'b0));
        run(1, 0, 5, 2, 30);
        chk("R8 coincide first pulse", firstp[2], exp_wake(0, 5));
        chk("R8 coincide sleep fall", wake_i[2], exp_wake(0, 5));
        chk("R8 coincide second pulse", lastp[2], exp_wake(5, 5));
        chk("R8 coincide pulse count", npul[2], 2);

        // R9: first-only ignores later edges until re-armed
        do_reset();
        wr(0, 1'b0, 16'd10);
        wr(0, 1'b1, ctrl_word(1'b1, 4'h1, 2'd0, 1'b1));
        run(0, 0, 4, 2, 40);
        chk("R9 first edge used", wake_i[0], exp_wake(0, 10));
        chk("R9 later edge ignored", npul[0], 1);
        run(0, 0, -1, 2, 20); chk("R9 still blocked", npul[0], 0);
        wr(0, 1'b1, ctrl_word(1'b1, 4'h1, 2'd0, 1'b0));
        run(0, 0, -1, 2, 20);
        chk("R9 re-armed pulse", firstp[0], exp_wake(0, 10));

        // R12: one pin wakes two channels at their own times
        do_reset();
        wr(1, 1'b0, 16'd3);
        wr(2, 1'b0, 16'd7);
        wr(1, 1'b1, ctrl_word(1'b1, 4'h2, 2'd1, 1'b0));
        wr(2, 1'b1, ctrl_word(1'b1, 4'h2, 2'd1, 1'b0));
        run(1, 1, -1, 3, 20);
        chk("R12 channel 1 wake", wake_i[1], exp_wake(1, 3));
        chk("R12 channel 2 wake", wake_i[2], exp_wake(1, 7));
        chk("R12 others asleep", {ch_sleep[3], ch_sleep[0]}, 2'b11);

        // R2/R6/R12: seeded random channel, select, enables and hold-off
        for (int it = 0; it < 10; it++) begin
            int ch; int sel; int h; int r1; logic [3:0] pen;
            ch  = int'($urandom % 4);
            sel = int'($urandom % 4);
            h   = 1 + int'($urandom % 40);
            r1  = int'($urandom % 4);
            pen = 4'($urandom) | (4'b1 << sel);
            do_reset();
            wr(ch, 1'b0, 16'(h));
            wr(ch, 1'b1, ctrl_word(1'b1, pen, 2'(sel), 1'b0));
            run(sel, r1, -1, 3, r1 + h + 10);
            chk("R6 random latency", wake_i[ch], exp_wake(r1, h));
            chk("R2 random single pulse", npul[ch], 1);
            chk("R12 random others asleep", ch_sleep | (4'b1 << ch), 4'hF);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule